// File: doc/BRIEF.md
# Banked SRAM Power-Mode Controller

A behavioural, synthesizable model of an 8192 x 32 single-port SRAM. The array is cut into four equal banks, and each bank has its own power state: on, retaining (asleep with contents kept) or off (unpowered, contents lost). The shared periphery has a separate power state with four levels: on, light nap, deep nap and off. Every mix of bank states is legal at the same time.

An access is carried out only when the periphery is on and has finished waking, and the addressed bank is on. Any other access is dropped, and an error strobe reports it. A bank that has been off returns a fixed poison word for each word not yet rewritten. After the periphery is switched back on, the ready output stays low for a number of cycles that depends on how deep the state it left was.

Top module: `sram_pwr_ctrl`

## Requirements
- R1: While rst_ni is low and right after its release, ready_o, err_o and rvalid_o are low. Reset puts every bank and the periphery into their off state.
- R2: addr_i[12:11] selects the bank and addr_i[10:0] selects the word. A word written to one bank reads back unchanged and does not disturb the same word offset in another bank.
- R3: Bank mode codes sit in bank_mode_i[2b+1:2b] for bank b: 00 on, 01 retaining, 10 or 11 off. A request to a bank whose registered mode is not on is dropped, and err_o is high in the following cycle.
- R4: Contents of a bank held in retaining mode are still readable after the bank returns to on.
- R5: A bank in the off state loses its contents. It also starts in that state after reset. Until a word is written again, a read of it returns 0xDEADBEEF.
- R6: Banks are independent: with some banks off or retaining, requests to banks that are on still complete normally.
- R7: Periphery mode codes on periph_mode_i: 00 on, 01 light nap, 10 deep nap, 11 off. When the mode goes from light nap to on, ready_o stays low for exactly 1 cycle after the first edge that samples on.
- R8: Waking from deep nap holds ready_o low for DEEP_WAKE (4) cycles.
- R9: Waking from off holds ready_o low for OFF_WAKE (16) cycles.
- R10: A request while ready_o is low is dropped, and err_o is high in the following cycle.
- R11: An accepted read drives rvalid_o high and places the data on rdata_o in the cycle after the request. rvalid_o and err_o are single-cycle strobes.
- R12: A request is dropped with err_o in two cases: if the addressed bank's mode input differs from its registered mode in the same cycle, or if periph_mode_i is not on in that cycle.
- R13: err_o and rvalid_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_mode_i | input | 8 | Requested mode, two bits per bank |
| periph_mode_i | input | 2 | Requested periphery mode |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 13 | Word address, bank in top two bits |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | Read data valid strobe |
| err_o | output | 1 | Dropped-request strobe |
| ready_o | output | 1 | Periphery on and awake |

## Verification
Read data, rvalid_o and err_o are all due one edge after the request edge, so each access task drives the request, waits one edge and samples 1 ns later. It then waits one more edge to confirm the strobe has dropped. Mode changes are registered at the edge, so the bench applies a mode one edge before any access that depends on it. The exception is the abort case, where the mode change and the request are driven together on purpose. For wake-up, the bench counts the cycles with ready_o low, starting from the first edge that samples the on code, and compares the count with the latency expected for the state left.

// File: rtl/sram_pwr_pkg.sv
`timescale 1ns/1ps
package sram_pwr_pkg;
  typedef enum logic [1:0] {
    BANK_ON   = 2'b00,
    BANK_RET  = 2'b01,
    BANK_OFF  = 2'b10,
    BANK_OFF2 = 2'b11
  } bank_mode_e;

  typedef enum logic [1:0] {
    PER_ON    = 2'b00,
    PER_LIGHT = 2'b01,
    PER_DEEP  = 2'b10,
    PER_OFF   = 2'b11
  } periph_mode_e;
endpackage

// File: rtl/sram_periph_ctrl.sv
`timescale 1ns/1ps
module sram_periph_ctrl
  import sram_pwr_pkg::*;
#(
  parameter int LIGHT_WAKE = 1,
  parameter int DEEP_WAKE  = 4,
  parameter int OFF_WAKE   = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  output logic       ready_o,
  output logic       ok_o
);
  localparam int MAX_WAKE = (OFF_WAKE > DEEP_WAKE) ? OFF_WAKE : DEEP_WAKE;
  localparam int CNT_W    = $clog2(MAX_WAKE + 1);

  periph_mode_e     mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] wake_lat;

  always_comb begin
    unique case (mode_q)
      PER_LIGHT: wake_lat = CNT_W'(LIGHT_WAKE);
      PER_DEEP:  wake_lat = CNT_W'(DEEP_WAKE);
      PER_OFF:   wake_lat = CNT_W'(OFF_WAKE);
      default:   wake_lat = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PER_OFF;
      cnt_q  <= '0;
    end else begin
      mode_q <= periph_mode_e'(mode_i);
      if (mode_i == PER_ON) begin
        if (mode_q != PER_ON)  cnt_q <= wake_lat;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign ready_o = (mode_q == PER_ON) && (cnt_q == '0);
  // a mode request in the same cycle aborts the access
  assign ok_o    = ready_o && (mode_i == PER_ON);
endmodule

// File: rtl/sram_bank.sv
`timescale 1ns/1ps
module sram_bank
  import sram_pwr_pkg::*;
#(
  parameter int              WORDS  = 2048,
  parameter int              DATA_W = 32,
  parameter logic [DATA_W-1:0] POISON = 32'hDEADBEEF,
  localparam int             AW     = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  output logic              active_o,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  bank_mode_e        mode_q;
  logic [DATA_W-1:0] mem_q [WORDS];
  logic [WORDS-1:0]  valid_q;
  logic [DATA_W-1:0] rdata_q;
  logic              off_q;

  assign off_q = mode_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= BANK_OFF;
    else         mode_q <= bank_mode_e'(mode_i);
  end

  // on only when registered and requested modes agree
  assign active_o = (mode_q == BANK_ON) && (mode_i == BANK_ON);

  always_ff @(posedge clk_i) begin
    if (en_i && we_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      rdata_q <= '0;
    end else begin
      if (off_q)             valid_q <= '0;
      else if (en_i && we_i) valid_q[addr_i] <= 1'b1;
      if (en_i && !we_i)
        rdata_q <= valid_q[addr_i] ? mem_q[addr_i] : POISON;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/sram_access_ctrl.sv
`timescale 1ns/1ps
module sram_access_ctrl #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 13,
  localparam int BSEL_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 periph_ok_i,
  input  logic [NUM_BANKS-1:0] bank_ok_i,
  output logic [NUM_BANKS-1:0] bank_en_o,
  output logic [BSEL_W-1:0]    rsel_o,
  output logic                 rvalid_o,
  output logic                 err_o
);
  logic [BSEL_W-1:0] bsel;
  logic              accept;
  logic [BSEL_W-1:0] rsel_q;
  logic              rvalid_q, err_q;

  assign bsel   = addr_i[ADDR_W-1 -: BSEL_W];
  assign accept = req_i && periph_ok_i && bank_ok_i[bsel];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_en
    assign bank_en_o[b] = accept && (bsel == BSEL_W'(b));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsel_q   <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= accept && !we_i;
      err_q    <= req_i && !accept;
      if (accept && !we_i) rsel_q <= bsel;
    end
  end

  assign rsel_o   = rsel_q;
  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;
endmodule

// File: rtl/sram_pwr_ctrl.sv
`timescale 1ns/1ps
module sram_pwr_ctrl #(
  parameter int                NUM_BANKS      = 4,
  parameter int                WORDS_PER_BANK = 2048,
  parameter int                DATA_W         = 32,
  parameter int                LIGHT_WAKE     = 1,
  parameter int                DEEP_WAKE      = 4,
  parameter int                OFF_WAKE       = 16,
  parameter logic [DATA_W-1:0] POISON         = 32'hDEADBEEF,
  localparam int               BANK_AW        = $clog2(WORDS_PER_BANK),
  localparam int               BSEL_W         = $clog2(NUM_BANKS),
  localparam int               ADDR_W         = BANK_AW + BSEL_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2*NUM_BANKS-1:0] bank_mode_i,
  input  logic [1:0]             periph_mode_i,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   rvalid_o,
  output logic                   err_o,
  output logic                   ready_o
);
  logic                 periph_ok;
  logic [NUM_BANKS-1:0] bank_ok, bank_en;
  logic [BSEL_W-1:0]    rsel;
  logic [DATA_W-1:0]    bank_rdata [NUM_BANKS];

  sram_periph_ctrl #(
    .LIGHT_WAKE(LIGHT_WAKE), .DEEP_WAKE(DEEP_WAKE), .OFF_WAKE(OFF_WAKE)
  ) u_periph (
    .clk_i, .rst_ni, .mode_i(periph_mode_i), .ready_o, .ok_o(periph_ok)
  );

  sram_access_ctrl #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_access (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i,
    .periph_ok_i(periph_ok), .bank_ok_i(bank_ok), .bank_en_o(bank_en),
    .rsel_o(rsel), .rvalid_o, .err_o
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sram_bank #(.WORDS(WORDS_PER_BANK), .DATA_W(DATA_W), .POISON(POISON)) u_bank (
      .clk_i, .rst_ni,
      .mode_i  (bank_mode_i[2*b +: 2]),
      .active_o(bank_ok[b]),
      .en_i    (bank_en[b]),
      .we_i,
      .addr_i  (addr_i[BANK_AW-1:0]),
      .wdata_i,
      .rdata_o (bank_rdata[b])
    );
  end

  assign rdata_o = bank_rdata[rsel];
endmodule

// File: rtl/sram_pwr_ctrl_checker.sv
`timescale 1ns/1ps
module sram_pwr_ctrl_checker #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 13,
  localparam int BSEL_W   = $clog2(NUM_BANKS)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [2*NUM_BANKS-1:0] bank_mode_i,
  input logic [1:0]             periph_mode_i,
  input logic                   req_i,
  input logic                   we_i,
  input logic [ADDR_W-1:0]      addr_i,
  input logic                   rvalid_o,
  input logic                   err_o,
  input logic                   ready_o
);
  logic [BSEL_W-1:0] tgt;
  logic [1:0]        tgt_mode;
  assign tgt      = addr_i[ADDR_W-1 -: BSEL_W];
  assign tgt_mode = bank_mode_i[{tgt, 1'b0} +: 2];

  a_r13_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_o && rvalid_o));

  a_r10_not_ready_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ready_o) |=> (err_o && !rvalid_o));

  a_r3_bank_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && tgt_mode != 2'b00) |=> err_o);

  a_r12_periph_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && periph_mode_i != 2'b00) |=> err_o);

  a_r11_rvalid_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i && ready_o));

  a_r9_ready_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(periph_mode_i) == 2'b00);
endmodule

bind sram_pwr_ctrl sram_pwr_ctrl_checker #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bank_mode_i(bank_mode_i),
  .periph_mode_i(periph_mode_i), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .rvalid_o(rvalid_o), .err_o(err_o), .ready_o(ready_o)
);

// File: tb/tb_sram_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_sram_pwr_ctrl;
  localparam logic [31:0] POISON = 32'hDEADBEEF;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  bank_mode_i = 8'h00;
  logic [1:0]  periph_mode_i = 2'b00;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [12:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o, err_o, ready_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  sram_pwr_ctrl dut (.*);

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] ad(input int b, input int w);
    return {2'(b), 11'(w)};
  endfunction

  task automatic access(input bit w, input logic [12:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    tick();
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic write_ok(input logic [12:0] a, input logic [31:0] d, input string req);
    access(1'b1, a, d);
    chk(!err_o && !rvalid_o, req, {30'd0, err_o, rvalid_o}, 32'd0);
  endtask

  task automatic read_chk(input logic [12:0] a, input logic [31:0] exp, input string req);
    access(1'b0, a, '0);
    chk(rvalid_o && !err_o, {req, " R11 strobe"}, {30'd0, err_o, rvalid_o}, 32'd1);
    chk(rdata_o == exp, req, rdata_o, exp);
    tick();
    chk(!rvalid_o, "R11 pulse width", {31'd0, rvalid_o}, 32'd0);
  endtask

  task automatic reject_chk(input bit w, input logic [12:0] a, input string req);
    access(w, a, 32'h1234_5678);
    chk(err_o && !rvalid_o, req, {30'd0, err_o, rvalid_o}, 32'd2);
    tick();
    chk(!err_o, {req, " R11 err pulse"}, {31'd0, err_o}, 32'd0);
  endtask

  task automatic wake_chk(input int exp, input string req);
    int n = 0;
    periph_mode_i = 2'b00;
    tick();
    while (!ready_o && n < 100) begin
      n++;
      tick();
    end
    chk(n == exp, req, n, exp);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    bank_mode_i = 8'h00; periph_mode_i = 2'b00;
    tick(); tick();
    chk(!ready_o && !err_o && !rvalid_o, "R1 in reset", {29'd0, ready_o, err_o, rvalid_o}, 32'd0);
    #1 rst_ni = 1'b1;
    #0.5;
    chk(!ready_o, "R1 after release", {31'd0, ready_o}, 32'd0);
    wake_chk(16, "R9 wake from off");
  endtask

  task automatic t_map();
    read_chk(ad(0, 7), POISON, "R5 poison after reset");
    for (int b = 0; b < 4; b++) write_ok(ad(b, 5), 32'hA000_0000 + b, "R2 write");
    for (int b = 0; b < 4; b++) read_chk(ad(b, 5), 32'hA000_0000 + b, "R2 readback");
    write_ok(ad(2, 2047), 32'h5555_AAAA, "R2 top word");
    read_chk(ad(2, 2047), 32'h5555_AAAA, "R2 top word");
  endtask

  task automatic t_mixed();
    bank_mode_i = 8'b10_00_01_00;
    tick();
    reject_chk(1'b0, ad(1, 5), "R3 read retaining bank");
    reject_chk(1'b1, ad(3, 5), "R3 write off bank");
    read_chk(ad(0, 5), 32'hA000_0000, "R6 bank0 while others asleep");
    read_chk(ad(2, 5), 32'hA000_0002, "R6 bank2 while others asleep");
    bank_mode_i = 8'h00;
    tick();
    read_chk(ad(1, 5), 32'hA000_0001, "R4 retained after retain");
    read_chk(ad(3, 5), POISON, "R5 poison after off");
    write_ok(ad(3, 5), 32'hBEEF_0003, "R5 rewrite");
    read_chk(ad(3, 5), 32'hBEEF_0003, "R5 rewritten word");
    read_chk(ad(3, 6), POISON, "R5 other word still poison");
    read_chk(ad(2, 2047), 32'h5555_AAAA, "R6 bank2 untouched");
  endtask

  task automatic t_periph();
    periph_mode_i = 2'b01;
    tick();
    chk(!ready_o, "R7 light not ready", {31'd0, ready_o}, 32'd0);
    reject_chk(1'b0, ad(0, 5), "R10 access in light nap");
    wake_chk(1, "R7 light wake");
    periph_mode_i = 2'b10;
    tick();
    reject_chk(1'b1, ad(0, 5), "R10 access in deep nap");
    wake_chk(4, "R8 deep wake");
    read_chk(ad(0, 5), 32'hA000_0000, "R4 data across periph nap");
  endtask

  task automatic t_abort();
    bank_mode_i = 8'h01;
    reject_chk(1'b1, ad(0, 5), "R12 bank mode change aborts");
    bank_mode_i = 8'h00;
    tick();
    read_chk(ad(0, 5), 32'hA000_0000, "R12 aborted write left data");
    periph_mode_i = 2'b01;
    reject_chk(1'b0, ad(0, 5), "R12 periph mode change aborts");
    wake_chk(1, "R7 light wake again");
  endtask

  initial begin
    t_reset();
    t_map();
    t_mixed();
    t_periph();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule